// File: doc/BRIEF.md
# Masked Constrained Flag Enumerator

This block is a sequential stimulus source. It steps through every legal value of a 14-bit test-configuration vector. Each bit selects one aspect of a memory-access scenario: the kind of access, the attributes of the translation entries, and a few processor control enables. Downstream logic applies the presented vector to a permission checker, then asks for the next one by pulsing `advance`.

A run-time `mask` keeps selected bit positions at zero for the whole run, so the sequence only covers the unmasked positions. The next candidate is formed by an increment that carries straight through the masked positions. A fixed set of legality rules screens each candidate. Rejected candidates are stepped past one per clock, with `valid` held low, until a legal value appears or the count runs off the top of the vector width. The second case ends the run and raises `done`. A `start` pulse restarts the sequence from zero at any time.

Top module: `flag_enum_top`

## Requirements
- R1: One cycle after reset is released, and in the cycle after a `start` pulse, `vec` is all zeros, `valid` is 1 and `done` is 0.
- R2: The next candidate after value v is ((v | mask) + 1) & ~mask, computed one bit wider than the vector. A vector presented with `valid` high never has a bit set where `mask` is 1, provided `mask` is changed only while `done` is high or before `start`.
- R3: A candidate with bit 0 (write access) and bit 1 (instruction fetch) both set is rejected.
- R4: A candidate with bit 2 (user-level access) and bit 3 (supervisor execution guard enable) both set is rejected.
- R5: A candidate with bit 5 (key read block) or bit 6 (key write block) set while bit 4 (key protection enable) is clear is rejected.
- R6: A candidate with bit 8 (directory reserved bit 13) set while bit 7 (directory large-page) is clear is rejected.
- R7: A candidate is rejected if more than one of bits 8, 9 and 10 (directory reserved bits 13, 36, 51) is set, or if bits 11 and 12 (table reserved bits 36, 51) are both set. Bit 13 (directory present) is never a cause of rejection.
- R8: Every legal unmasked value is presented exactly once, in strictly ascending order.
- R9: One candidate is examined per clock. After an accepted `advance`, `valid` stays low for exactly as many cycles as there are rejected candidates before the next legal one.
- R10: When the increment carries out of the top bit, `done` rises with `valid` low and `vec` zero. This happens after as many low cycles as there were rejected candidates after the last legal value.
- R11: Once set, `done` stays high and `advance` has no effect until the next `start`.
- R12: While `valid` is high and `advance` is low, `vec` and `valid` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Restart the sequence at zero |
| advance | input | 1 | Request the next legal vector; taken only while `valid` is high |
| mask | input | 14 | Bit positions forced to zero during the run |
| vec | output | 14 | Current configuration vector |
| valid | output | 1 | `vec` is a legal vector ready for use |
| done | output | 1 | Sequence exhausted |

## Verification
The embedded assertions check, on every cycle, properties that hold at any instant. A valid vector always satisfies the legality rules and has no masked bits. Vectors rise across each accepted advance. The block holds while idle. `done` is sticky, a start always restarts at zero, and a carry out of the top bit ends the run. Only the bench's full runs can show completeness, meaning that no legal value is skipped and none is repeated. The same runs show that the number of low-`valid` cycles matches the count of rejected candidates, and that different masks shape the sequence correctly. For that, the bench compares each run against a list it builds independently for masks of zero, a narrow mask and a mask that removes the execution-guard and key-enable bits.

// File: rtl/flag_enum_pkg.sv
package flag_enum_pkg;

  // Bit positions inside the configuration vector.
  localparam int unsigned POS_ACC_WR   = 0;
  localparam int unsigned POS_ACC_FE   = 1;
  localparam int unsigned POS_ACC_USR  = 2;
  localparam int unsigned POS_EXEC_GRD = 3;
  localparam int unsigned POS_KEY_EN   = 4;
  localparam int unsigned POS_KEY_RD   = 5;
  localparam int unsigned POS_KEY_WR   = 6;
  localparam int unsigned POS_DIR_BIG  = 7;
  localparam int unsigned POS_DIR_R13  = 8;
  localparam int unsigned POS_DIR_R36  = 9;
  localparam int unsigned POS_DIR_R51  = 10;
  localparam int unsigned POS_TBL_R36  = 11;
  localparam int unsigned POS_TBL_R51  = 12;
  localparam int unsigned POS_DIR_PRS  = 13;
  localparam int unsigned MIN_FLAG_W   = 14;

  typedef enum logic [1:0] {
    ST_OUT  = 2'd0,
    ST_SEEK = 2'd1,
    ST_END  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/flag_stepper.sv
module flag_stepper #(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] mask,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam int unsigned SW = W + 1;

  logic [SW-1:0] filled;
  logic [SW-1:0] sum;

  always_comb begin
    filled = {1'b0, cur | mask};
    sum    = filled + {{(SW-1){1'b0}}, 1'b1};
    nxt    = sum[W-1:0] & ~mask;
    wrap   = sum[SW-1];
  end

endmodule

// File: rtl/flag_rules.sv
module flag_rules
  import flag_enum_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic [W-1:0] cand,
  output logic         ok
);
  localparam int unsigned NUM_RULES = 6;

  logic [NUM_RULES-1:0] bad;
  logic [1:0]           dir_rsv_cnt;

  generate
    if (W < MIN_FLAG_W) begin : g_width_err
      // Elaboration fails with a clear message on a too-narrow vector.
      $error("flag_rules: W must be at least %0d", MIN_FLAG_W);
    end
  endgenerate

  always_comb begin
    dir_rsv_cnt = {1'b0, cand[POS_DIR_R13]} + {1'b0, cand[POS_DIR_R36]}
                + {1'b0, cand[POS_DIR_R51]};
    bad[0] = cand[POS_ACC_WR] & cand[POS_ACC_FE];
    bad[1] = cand[POS_ACC_USR] & cand[POS_EXEC_GRD];
    bad[2] = ~cand[POS_KEY_EN] & (cand[POS_KEY_RD] | cand[POS_KEY_WR]);
    bad[3] = ~cand[POS_DIR_BIG] & cand[POS_DIR_R13];
    bad[4] = dir_rsv_cnt > 2'd1;
    bad[5] = cand[POS_TBL_R36] & cand[POS_TBL_R51];
    ok     = ~|bad;
  end

endmodule

// File: rtl/flag_seq_ctrl.sv
module flag_seq_ctrl
  import flag_enum_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         advance,
  input  logic [W-1:0] cand,
  input  logic         cand_wrap,
  input  logic         cand_ok,
  output logic [W-1:0] cur,
  output logic         valid,
  output logic         done
);
  seq_state_e   st_q, st_d;
  logic [W-1:0] cur_q, cur_d;
  logic         cur_en;
  logic         step;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    cur_en = 1'b0;
    step   = 1'b0;
    if (start) begin
      st_d   = ST_OUT;
      cur_d  = '0;
      cur_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_OUT:  step = advance;
        ST_SEEK: step = 1'b1;
        default: step = 1'b0;
      endcase
      if (step) begin
        cur_en = 1'b1;
        if (cand_wrap) begin
          st_d  = ST_END;
          cur_d = '0;
        end else begin
          cur_d = cand;
          st_d  = cand_ok ? ST_OUT : ST_SEEK;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OUT;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  assign cur   = cur_q;
  assign valid = (st_q == ST_OUT);
  assign done  = (st_q == ST_END);

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R1
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (valid && !done && cur == '0));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !advance && !start) |=> (valid && $stable(cur)));

  // R10
  wrap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((valid && advance) || (!valid && !done)) && cand_wrap && !start)
      |=> (done && !valid && cur == '0));

  // R9
  seek_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((valid && advance) || (!valid && !done)) && !cand_wrap && !cand_ok && !start)
      |=> (!valid && !done));

endmodule

// File: rtl/flag_enum_top.sv
module flag_enum_top
  import flag_enum_pkg::*;
#(
  parameter int unsigned FLAG_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              advance,
  input  logic [FLAG_W-1:0] mask,
  output logic [FLAG_W-1:0] vec,
  output logic              valid,
  output logic              done
);
  logic [FLAG_W-1:0] cand;
  logic              cand_wrap;
  logic              cand_ok;
  logic              vec_ok;

  flag_stepper #(.W(FLAG_W)) u_step (
    .cur  (vec),
    .mask (mask),
    .nxt  (cand),
    .wrap (cand_wrap)
  );

  flag_rules #(.W(FLAG_W)) u_rules (
    .cand (cand),
    .ok   (cand_ok)
  );

  flag_seq_ctrl #(.W(FLAG_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .advance   (advance),
    .cand      (cand),
    .cand_wrap (cand_wrap),
    .cand_ok   (cand_ok),
    .cur       (vec),
    .valid     (valid),
    .done      (done)
  );

  // Second screen on the presented vector, used only by the check below.
  flag_rules #(.W(FLAG_W)) u_out_rules (
    .cand (vec),
    .ok   (vec_ok)
  );

  // R3 R4 R5 R6 R7
  legal_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> vec_ok);

  // R2
  masked_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((vec & mask) == '0));

  // R8
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && advance && !start) |=> (done || vec > $past(vec)));

endmodule

// File: tb/flag_enum_top_tb_top.sv
module flag_enum_top_tb_top;
  localparam int W = 14;

  typedef struct {
    logic [W-1:0] v;
    int           gap;
    bit           last;
  } exp_item_t;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         advance;
  logic [W-1:0] mask;
  logic [W-1:0] vec;
  logic         valid;
  logic         done;

  int n_tests = 0;
  int n_fail  = 0;
  exp_item_t exp_q[$];

  flag_enum_top #(.FLAG_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .advance(advance),
    .mask(mask), .vec(vec), .valid(valid), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic bit legal(logic [W-1:0] v);
    int dr;
    dr = int'(v[8]) + int'(v[9]) + int'(v[10]);
    if (v[0] && v[1]) return 0;                 // R3
    if (v[2] && v[3]) return 0;                 // R4
    if (!v[4] && (v[5] || v[6])) return 0;      // R5
    if (!v[7] && v[8]) return 0;                // R6
    if (dr > 1 || (v[11] && v[12])) return 0;   // R7
    return 1;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: build the expected sequence for one mask.
  task automatic fill_queue(logic [W-1:0] m);
    int gap;
    exp_q.delete();
    gap = 0;
    for (int v = 0; v < (1 << W); v++) begin
      if ((v & int'(m)) != 0) continue;
      if (legal(W'(v))) begin
        exp_q.push_back('{v: W'(v), gap: gap, last: 1'b0});
        gap = 0;
      end else begin
        gap++;
      end
    end
    exp_q.push_back('{v: '0, gap: gap, last: 1'b1});
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(valid && !done && vec == '0, "R1 start", vec, '0);
  endtask

  // Monitor: pop expected items and compare as the design presents them.
  task automatic run_monitor(logic [W-1:0] m);
    exp_item_t it;
    int gap;
    bit first;
    first = 1'b1;
    while (exp_q.size() > 0) begin
      it = exp_q.pop_front();
      if (!first) begin
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
        gap = 0;
        while (!valid && !done) begin
          gap++;
          @(negedge clk);
        end
        check(gap == it.gap, it.last ? "R10 end latency" : "R9 reject cycles",
              W'(gap), W'(it.gap));
      end
      first = 1'b0;
      if (it.last) begin
        check(done && !valid && vec == '0, "R10 done state", vec, '0);
      end else begin
        check(valid && !done && vec == it.v, "R8 sequence", vec, it.v);
        check((vec & m) == '0, "R2 masked bits", vec & m, '0);
      end
    end
  endtask

  task automatic full_run(logic [W-1:0] m);
    @(negedge clk);
    mask = m;
    fill_queue(m);
    pulse_start();
    run_monitor(m);
  endtask

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    advance = 1'b0;
    mask    = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid && !done && vec == '0, "R1 reset", vec, '0);

    // R12: hold with no advance
    repeat (5) @(negedge clk);
    check(valid && vec == '0, "R12 hold", vec, '0);

    // Full run, no mask: covers R2..R10
    full_run('0);

    // R11: done is sticky, advance ignored
    for (int i = 0; i < 4; i++) begin
      advance = 1'b1;
      @(negedge clk);
    end
    advance = 1'b0;
    @(negedge clk);
    check(done && !valid && vec == '0, "R11 sticky", vec, '0);

    // R1: restart mid-run, then R12 hold on a nonzero vector
    pulse_start();
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(valid && vec == 14'h0001, "R3 write alone legal", vec, 14'h0001);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(valid && vec == 14'h0002, "R3 fetch alone legal", vec, 14'h0002);
    repeat (3) @(negedge clk);
    check(valid && vec == 14'h0002, "R12 hold nonzero", vec, 14'h0002);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
    check(!valid && !done, "R3 write+fetch rejected", {13'b0, valid}, '0);
    @(negedge clk);
    check(valid && vec == 14'h0004, "R9 next after reject", vec, 14'h0004);
    pulse_start();

    // Masked runs
    full_run(14'h3F81);   // R2 narrow vector, write bit disabled
    full_run(14'h0018);   // R4 R5 guard and key enable disabled
    full_run(14'h2000);   // R6 R7 reserved-bit rules

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule